// File: doc/BRIEF.md
# RNS Addition Overflow Detector

This block decides whether the sum of two addends held in residue form over the three moduli 2^n+1, 2^n and 2^n−1 leaves the dynamic range M = 2^n(2^n+1)(2^n−1). It does not see the residues themselves. Instead it receives, for each addend, the two upper mixed-radix digits that an upstream partial converter has already produced.

Each addend is written as X = e1 + e2·(2^n+1) + e3·(2^n+1)·2^n. The block uses e2 and e3 to tell whether the addend lies in the lower half (X < M/2) or the upper half (X ≥ M/2) of the range. If both addends are in the same half, the outcome is fixed without any further information. If they lie in different halves, the block passes through a tie-break bit supplied by the sum reconstruction stage, which asserts that bit when the reconstructed binary sum reaches M.

The two half-range flags and the overflow bit are registered. They appear one clock after the digits are presented. A synchronous active-high reset clears all three outputs.

Top module: `rns_ovf_detector`

## Requirements
- R1: An addend's half-range flag is 1 when its digit e3 (unsigned, N bits) is greater than or equal to 2^(N-1).
- R2: An addend's half-range flag is 1 when e3 equals 2^(N-1)−1 and its digit e2 (unsigned, N bits) is greater than or equal to 2^(N-1).
- R3: For every other digit combination the flag is 0, so the flag equals (X ≥ M/2) for every in-range addend.
- R4: When both half-range flags are 0, the overflow output is 0 whatever the value of the tie-break input.
- R5: When both half-range flags are 1, the overflow output is 1 whatever the value of the tie-break input.
- R6: When exactly one half-range flag is 1, the overflow output equals the tie-break input.
- R7: x_upper, y_upper and ovf change one clock edge after their inputs. While rst is high at a rising edge, all three outputs are cleared to 0.
- R8: When the tie-break input equals (X+Y ≥ M), the overflow output equals (X+Y ≥ M) for every pair of in-range addends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_e2 | input | N | Middle mixed-radix digit of addend X |
| x_e3 | input | N | Top mixed-radix digit of addend X |
| y_e2 | input | N | Middle mixed-radix digit of addend Y |
| y_e3 | input | N | Top mixed-radix digit of addend Y |
| lambda_in | input | 1 | Tie-break bit: 1 when the reconstructed sum reaches M |
| x_upper | output | 1 | Registered flag, X ≥ M/2 |
| y_upper | output | 1 | Registered flag, Y ≥ M/2 |
| ovf | output | 1 | Registered overflow decision |

## Verification
The bench goes after the digit row just below the midpoint, where e3 = 2^(N-1)−1. A classifier that tested only e3 there, or that required e2 to equal the midpoint digit exactly, would misjudge addends between M/2 and the next e3 row. It also drives tie-break values that contradict the pair's halves. This exposes a resolver that consults the tie-break in the fixed cases, or one that ignores it in the mixed case. Exhaustive N=2 pairs and random N=3 and N=4 pairs, including the pair that sums to exactly M, catch an off-by-one at the range limit. A reset applied during an overflow shows whether the registers clear.

// File: rtl/rns_ovf_pkg.sv
package rns_ovf_pkg;

  typedef enum logic [1:0] {
    PAIR_LOW   = 2'd0,
    PAIR_MIXED = 2'd1,
    PAIR_HIGH  = 2'd2
  } pair_class_e;

  function automatic pair_class_e classify_pair(input logic hi_a, input logic hi_b);
    if (hi_a && hi_b)       return PAIR_HIGH;
    else if (hi_a || hi_b)  return PAIR_MIXED;
    else                    return PAIR_LOW;
  endfunction

endpackage

// File: rtl/rns_half_range_cmp.sv
module rns_half_range_cmp #(
  parameter int N = 4
) (
  input  logic [N-1:0] e2,
  input  logic [N-1:0] e3,
  output logic         upper
);
  localparam logic [N-1:0] HALF    = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] HALF_M1 = HALF - 1'b1;

  logic top_high;
  logic edge_row;
  logic mid_high;

  always_comb begin
    top_high = (e3 >= HALF);
    edge_row = (e3 == HALF_M1);
    mid_high = (e2 >= HALF);
    upper    = top_high | (edge_row & mid_high);
  end
endmodule

// File: rtl/rns_ovf_resolve.sv
module rns_ovf_resolve
  import rns_ovf_pkg::*;
(
  input  logic beta_x,
  input  logic beta_y,
  input  logic lambda_in,
  output logic ovf
);
  pair_class_e cls;

  always_comb begin
    cls = classify_pair(beta_x, beta_y);
    unique case (cls)
      PAIR_HIGH:  ovf = 1'b1;
      PAIR_MIXED: ovf = lambda_in;
      default:    ovf = 1'b0;
    endcase
  end
endmodule

// File: rtl/rns_ovf_detector.sv
module rns_ovf_detector #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] x_e2,
  input  logic [N-1:0] x_e3,
  input  logic [N-1:0] y_e2,
  input  logic [N-1:0] y_e3,
  input  logic         lambda_in,
  output logic         x_upper,
  output logic         y_upper,
  output logic         ovf
);
  localparam int NUM_ADD = 2;

  logic [NUM_ADD-1:0][N-1:0] e2_v;
  logic [NUM_ADD-1:0][N-1:0] e3_v;
  logic [NUM_ADD-1:0]        upper_c;
  logic                      ovf_c;

  assign e2_v = {y_e2, x_e2};
  assign e3_v = {y_e3, x_e3};

  for (genvar i = 0; i < NUM_ADD; i++) begin : g_addend
    rns_half_range_cmp #(.N(N)) u_cmp (
      .e2    (e2_v[i]),
      .e3    (e3_v[i]),
      .upper (upper_c[i])
    );
  end

  rns_ovf_resolve u_res (
    .beta_x    (upper_c[0]),
    .beta_y    (upper_c[1]),
    .lambda_in (lambda_in),
    .ovf       (ovf_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_upper <= 1'b0;
      y_upper <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      x_upper <= upper_c[0];
      y_upper <= upper_c[1];
      ovf     <= ovf_c;
    end
  end
endmodule

// File: rtl/rns_ovf_detector_chk.sv
module rns_ovf_detector_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] x_e2,
  input logic [N-1:0] x_e3,
  input logic [N-1:0] y_e2,
  input logic [N-1:0] y_e3,
  input logic         lambda_in,
  input logic         x_upper,
  input logic         y_upper,
  input logic         ovf
);
  localparam logic [N-1:0] HALF    = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] HALF_M1 = HALF - 1'b1;

  p_upper_digit_x_r1: assert property (@(posedge clk) disable iff (rst)
    (!rst && x_e3 >= HALF) |=> x_upper);
  p_upper_digit_y_r1: assert property (@(posedge clk) disable iff (rst)
    (!rst && y_e3 >= HALF) |=> y_upper);

  p_edge_row_x_r2: assert property (@(posedge clk) disable iff (rst)
    (!rst && x_e3 == HALF_M1 && x_e2 >= HALF) |=> x_upper);
  p_edge_row_y_r2: assert property (@(posedge clk) disable iff (rst)
    (!rst && y_e3 == HALF_M1 && y_e2 >= HALF) |=> y_upper);

  p_lower_x_r3: assert property (@(posedge clk) disable iff (rst)
    (!rst && (x_e3 < HALF_M1 || (x_e3 == HALF_M1 && x_e2 < HALF))) |=> !x_upper);
  p_lower_y_r3: assert property (@(posedge clk) disable iff (rst)
    (!rst && (y_e3 < HALF_M1 || (y_e3 == HALF_M1 && y_e2 < HALF))) |=> !y_upper);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (!x_upper && !y_upper) |-> !ovf);

  p_sure_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (x_upper && y_upper) |-> ovf);

  p_mixed_follows_r6: assert property (@(posedge clk) disable iff (rst)
    (x_upper ^ y_upper) |-> (ovf == $past(lambda_in)));
endmodule

bind rns_ovf_detector rns_ovf_detector_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .x_e2      (x_e2),
  .x_e3      (x_e3),
  .y_e2      (y_e2),
  .y_e3      (y_e3),
  .lambda_in (lambda_in),
  .x_upper   (x_upper),
  .y_upper   (y_upper),
  .ovf       (ovf)
);

// File: tb/rns_ovf_detector_tb.sv
`timescale 1ns/1ps
module rns_ovf_detector_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [3:0] xe2 [3];
  logic [3:0] xe3 [3];
  logic [3:0] ye2 [3];
  logic [3:0] ye3 [3];
  logic       lm  [3];
  logic       xu  [3];
  logic       yu  [3];
  logic       ov  [3];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  rns_ovf_detector #(.N(2)) u_dut (
    .clk(clk), .rst(rst),
    .x_e2(xe2[0][1:0]), .x_e3(xe3[0][1:0]), .y_e2(ye2[0][1:0]), .y_e3(ye3[0][1:0]),
    .lambda_in(lm[0]), .x_upper(xu[0]), .y_upper(yu[0]), .ovf(ov[0]));
  rns_ovf_detector #(.N(3)) u_dut3 (
    .clk(clk), .rst(rst),
    .x_e2(xe2[1][2:0]), .x_e3(xe3[1][2:0]), .y_e2(ye2[1][2:0]), .y_e3(ye3[1][2:0]),
    .lambda_in(lm[1]), .x_upper(xu[1]), .y_upper(yu[1]), .ovf(ov[1]));
  rns_ovf_detector #(.N(4)) u_dut4 (
    .clk(clk), .rst(rst),
    .x_e2(xe2[2]), .x_e3(xe3[2]), .y_e2(ye2[2]), .y_e3(ye3[2]),
    .lambda_in(lm[2]), .x_upper(xu[2]), .y_upper(yu[2]), .ovf(ov[2]));

  function automatic int unsigned range_of(input int k);
    int unsigned p = 1 << (k + 2);
    return (p + 1) * p * (p - 1);
  endfunction

  function automatic int unsigned dig2(input int k, input int unsigned v);
    int unsigned p = 1 << (k + 2);
    return (v / (p + 1)) % p;
  endfunction

  function automatic int unsigned dig3(input int k, input int unsigned v);
    int unsigned p = 1 << (k + 2);
    return v / ((p + 1) * p);
  endfunction

  function automatic string beta_tag(input int k, input int unsigned v);
    int unsigned h = 1 << (k + 1);
    if (dig3(k, v) >= h) return "R1";
    if (dig3(k, v) == h - 1 && dig2(k, v) >= h) return "R2";
    return "R3";
  endfunction

  task automatic check(input bit act, input bit exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic run(input int k, input int unsigned xv, input int unsigned yv,
                     input bit lam, input string otag);
    int unsigned m = range_of(k);
    bit bx, by, eo;
    xe2[k] = 4'(dig2(k, xv));
    xe3[k] = 4'(dig3(k, xv));
    ye2[k] = 4'(dig2(k, yv));
    ye3[k] = 4'(dig3(k, yv));
    lm[k]  = lam;
    @(negedge clk);
    bx = (2 * xv >= m);
    by = (2 * yv >= m);
    eo = (bx && by) ? 1'b1 : ((!bx && !by) ? 1'b0 : lam);
    check(xu[k], bx, beta_tag(k, xv), $sformatf("x_upper k=%0d X=%0d", k, xv));
    check(yu[k], by, beta_tag(k, yv), $sformatf("y_upper k=%0d Y=%0d", k, yv));
    check(ov[k], eo, otag, $sformatf("ovf k=%0d X=%0d Y=%0d lam=%0b", k, xv, yv, lam));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int k = 0; k < 3; k++) begin
      xe2[k] = 4'hf; xe3[k] = 4'hf; ye2[k] = 4'hf; ye3[k] = 4'hf; lm[k] = 1'b1;
    end
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check(xu[k], 1'b0, "R7", "x_upper in reset");
      check(yu[k], 1'b0, "R7", "y_upper in reset");
      check(ov[k], 1'b0, "R7", "ovf in reset");
    end
    rst = 1'b0;

    // R1 / R2 / R3 digit boundaries, N=3 (M=504, M/2=252)
    run(1, 288, 0, 1'b0, "R6");
    run(1, 252, 251, 1'b0, "R6");
    run(1, 252, 252, 1'b1, "R5");
    // R4: both low, contradicting tie-break
    run(1, 10, 20, 1'b1, "R4");
    // R5: both high, contradicting tie-break
    run(1, 300, 400, 1'b0, "R5");
    // R6: mixed pair follows tie-break either way
    run(1, 300, 100, 1'b1, "R6");
    run(1, 300, 100, 1'b0, "R6");
    // N=4 edge row (M=4080, M/2=2040)
    run(2, 2040, 2039, 1'b0, "R6");
    run(2, 4079, 4079, 1'b1, "R8");
    run(2, 2040, 2040, 1'b1, "R8");

    // R7: reset while an overflow is being reported clears outputs
    run(1, 500, 500, 1'b1, "R5");
    rst = 1'b1;
    @(negedge clk);
    check(ov[1], 1'b0, "R7", "ovf after mid-run reset");
    check(xu[1], 1'b0, "R7", "x_upper after mid-run reset");
    rst = 1'b0;

    // R8: exhaustive N=2
    for (int unsigned a = 0; a < range_of(0); a++)
      for (int unsigned b = 0; b < range_of(0); b++)
        run(0, a, b, (a + b >= range_of(0)), "R8");

    // R8: random N=3 and N=4
    for (int k = 1; k < 3; k++)
      for (int i = 0; i < 2000; i++) begin
        int unsigned a = $urandom % range_of(k);
        int unsigned b = $urandom % range_of(k);
        run(k, a, b, (a + b >= range_of(k)), "R8");
      end

    finish_run();
  end
endmodule